// File: doc/BRIEF.md
# Asynchronous Event Coalescing Queue

This block sits between the sources of controller-side asynchronous events and the host's outstanding event requests. A producer presents an event made of a type code, an information code and the identifier of the log page the host should read to learn more. The block keeps a one-bit-per-type record of which types are already waiting or awaiting acknowledgement. A second event of a type that is already recorded is discarded, so the queue stays bounded even when the host never responds.

The host arms delivery by posting event requests, which fill a small pool of slots. Whenever at least one event is queued and at least one slot is open, the oldest event is removed, a packed completion result is presented for one cycle, and one slot is consumed. A type stays recorded after delivery. It is released only when the host reads the log page that the event named, and only if that read does not ask to keep the event. Error-type events are accepted only while the host has a slot open.

Top module: `aeq_top`

## Requirements
- R1: After reset the type record is all zero, no slots are open and `dlv_valid` is low.
- R2: An accepted event sets the record bit for its type in the same edge and is appended to the queue.
- R3: An event whose type bit is already set is dropped: it is never delivered and it does not consume a slot.
- R4: An event of type 0 (error) is dropped while the open slot count is zero. Other types are queued regardless of slots.
- R5: Each `req_post` pulse opens one slot, up to 4 slots. A post while 4 slots are open is ignored.
- R6: When the queue is non-empty and a slot is open, the head entry is removed. `dlv_valid` is high for one cycle, starting one clock after the removal decision, and the slot count drops by one. Entries leave in arrival order.
- R7: `dlv_result` packs the type into bits [2:0], the information code into bits [15:8] and the log page identifier into bits [23:16]. All other bits are zero.
- R8: A log read (`rd_valid`) with `rd_keep` low clears the record bit of every recorded type whose event named `rd_log`. With `rd_keep` high, the record is unchanged.
- R9: If an event of a type arrives in the same cycle as a log read that would clear that type, the event is accepted and the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Producer raises an event this cycle |
| ev_type | input | 3 | Event type code (0 = error, 1 = health) |
| ev_info | input | 8 | Event information code |
| ev_log | input | 8 | Log page identifier named by the event |
| req_post | input | 1 | Host posts one event request |
| rd_valid | input | 1 | Host read a log page this cycle |
| rd_log | input | 8 | Identifier of the log page read |
| rd_keep | input | 1 | Read asks to keep the event recorded |
| dlv_valid | output | 1 | Completion result valid for one cycle |
| dlv_result | output | 32 | Packed completion result |
| type_mask | output | 8 | Per-type record bits |
| open_slots | output | 3 | Number of outstanding host requests |

## Verification
A record bit that fails to clear looks at the ports like a silent drop. The next event of that type never produces a `dlv_valid` pulse, even though a slot is open, and this shows within two cycles of the raise. A corrupted queue pointer or slot counter shows as deliveries out of arrival order, wrong packed fields, or an `open_slots` value that does not match the posts minus the deliveries. These errors appear on the first delivery that follows the fault, which is one clock after the removal decision.

// File: rtl/aeq_pkg.sv
package aeq_pkg;
    localparam int TYPE_W = 3;
    localparam int INFO_W = 8;
    localparam int LOG_W  = 8;
    localparam int NTYPES = 1 << TYPE_W;

    typedef struct packed {
        logic [TYPE_W-1:0] etype;
        logic [INFO_W-1:0] info;
        logic [LOG_W-1:0]  logid;
    } aeq_entry_t;

    function automatic logic [31:0] pack_result(aeq_entry_t e);
        logic [31:0] r;
        r = '0;
        r[TYPE_W-1:0]  = e.etype;
        r[15:8]        = e.info;
        r[23:16]       = e.logid;
        return r;
    endfunction
endpackage

// File: rtl/aeq_fifo.sv
module aeq_fifo
    import aeq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  aeq_entry_t wdata,
    input  logic       pop,
    output aeq_entry_t rdata,
    output logic       empty,
    output logic       full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        aeq_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]          wp;
        logic [PW-1:0]          rp;
        logic [CW-1:0]          cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/aeq_slots.sv
module aeq_slots #(
    parameter int MAX_SLOTS = 4,
    localparam int SW = $clog2(MAX_SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          post,
    input  logic          take,
    output logic [SW-1:0] count
);
    typedef struct packed {
        logic [SW-1:0] cnt;
    } slot_st_t;

    slot_st_t st_q, st_d;
    logic post_ok;

    always_comb begin
        st_d    = st_q;
        post_ok = post && (st_q.cnt != SW'(MAX_SLOTS));
        st_d.cnt = st_q.cnt + SW'(post_ok) - SW'(take);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R5
    slot_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= SW'(MAX_SLOTS));
    // R6
    slot_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !post) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/aeq_mask.sv
module aeq_mask
    import aeq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [TYPE_W-1:0] set_type,
    input  logic [LOG_W-1:0]  set_log,
    input  logic              rd_en,
    input  logic [LOG_W-1:0]  rd_log,
    input  logic              rd_keep,
    output logic [NTYPES-1:0] clr_vec,
    output logic [NTYPES-1:0] mask
);
    typedef struct packed {
        logic [NTYPES-1:0]            bits;
        logic [NTYPES-1:0][LOG_W-1:0] log_of;
    } mask_st_t;

    mask_st_t st_q, st_d;
    logic [NTYPES-1:0] set_vec;

    for (genvar t = 0; t < NTYPES; t++) begin : g_clr
        assign clr_vec[t] = rd_en && !rd_keep && st_q.bits[t]
                            && (st_q.log_of[t] == rd_log);
        assign set_vec[t] = set_en && (set_type == TYPE_W'(t));
    end

    always_comb begin
        st_d = st_q;
        st_d.bits = (st_q.bits & ~clr_vec) | set_vec;
        if (set_en) st_d.log_of[set_type] = set_log;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask = st_q.bits;

    // R2
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> mask[$past(set_type)]);
    // R8
    keep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_keep && !set_en) |=> (mask == $past(mask)));
endmodule

// File: rtl/aeq_top.sv
module aeq_top
    import aeq_pkg::*;
#(
    parameter int MAX_SLOTS = 4,
    parameter int ERR_TYPE  = 0,
    localparam int SW = $clog2(MAX_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [TYPE_W-1:0] ev_type,
    input  logic [INFO_W-1:0] ev_info,
    input  logic [LOG_W-1:0]  ev_log,
    input  logic              req_post,
    input  logic              rd_valid,
    input  logic [LOG_W-1:0]  rd_log,
    input  logic              rd_keep,
    output logic              dlv_valid,
    output logic [31:0]       dlv_result,
    output logic [NTYPES-1:0] type_mask,
    output logic [SW-1:0]     open_slots
);
    typedef struct packed {
        logic        valid;
        logic [31:0] result;
    } dlv_st_t;

    dlv_st_t dlv_q, dlv_d;

    logic [NTYPES-1:0] clr_vec;
    logic [NTYPES-1:0] eff_mask;
    logic              accept, pop, empty, full;
    aeq_entry_t        head, wentry;

    always_comb begin
        eff_mask = type_mask & ~clr_vec;
        accept   = ev_valid && !eff_mask[ev_type] && !full
                   && !((ev_type == TYPE_W'(ERR_TYPE)) && (open_slots == '0));
        wentry   = '{etype: ev_type, info: ev_info, logid: ev_log};
        pop      = !empty && (open_slots != '0);
        dlv_d.valid  = pop;
        dlv_d.result = pop ? pack_result(head) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dlv_q <= '0;
        else        dlv_q <= dlv_d;
    end

    aeq_mask u_mask (
        .clk(clk), .rst_n(rst_n),
        .set_en(accept), .set_type(ev_type), .set_log(ev_log),
        .rd_en(rd_valid), .rd_log(rd_log), .rd_keep(rd_keep),
        .clr_vec(clr_vec), .mask(type_mask)
    );

    aeq_fifo #(.DEPTH(NTYPES)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(accept), .wdata(wentry),
        .pop(pop), .rdata(head), .empty(empty), .full(full)
    );

    aeq_slots #(.MAX_SLOTS(MAX_SLOTS)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .post(req_post), .take(pop), .count(open_slots)
    );

    assign dlv_valid  = dlv_q.valid;
    assign dlv_result = dlv_q.result;

    // R6
    pop_delivers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> dlv_valid);
    // R4
    err_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_type == TYPE_W'(ERR_TYPE) && open_slots == '0
         && !type_mask[ERR_TYPE]) |=> !type_mask[ERR_TYPE]);
endmodule

// File: tb/sim_aeq_top.sv
module sim_aeq_top;
    logic        clk = 0;
    logic        rst_n;
    logic        ev_valid, req_post, rd_valid, rd_keep;
    logic [2:0]  ev_type;
    logic [7:0]  ev_info, ev_log, rd_log;
    logic        dlv_valid;
    logic [31:0] dlv_result;
    logic [7:0]  type_mask;
    logic [2:0]  open_slots;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    aeq_top u0 (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ev_valid = 0; req_post = 0; rd_valid = 0; rd_keep = 0;
        ev_type = 0; ev_info = 0; ev_log = 0; rd_log = 0;
    endtask

    task automatic do_reset();
        idle(); rst_n = 0; tick(); tick(); rst_n = 1;
    endtask

    task automatic raise(logic [2:0] t, logic [7:0] i, logic [7:0] l);
        ev_valid = 1; ev_type = t; ev_info = i; ev_log = l;
        tick(); idle();
    endtask

    task automatic post(int n);
        for (int k = 0; k < n; k++) begin req_post = 1; tick(); end
        req_post = 0;
    endtask

    task automatic readlog(logic [7:0] l, bit keep);
        rd_valid = 1; rd_log = l; rd_keep = keep; tick(); idle();
    endtask

    // counts deliveries over n cycles, returns the last result
    task automatic watch(int n, output int cnt, output logic [31:0] res);
        cnt = 0; res = '0;
        for (int k = 0; k < n; k++) begin
            if (dlv_valid) begin cnt++; res = dlv_result; end
            tick();
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(type_mask == 0, "R1 mask", type_mask, 0);
        chk(open_slots == 0, "R1 slots", open_slots, 0);
        chk(dlv_valid == 0, "R1 valid", dlv_valid, 0);
    endtask

    task automatic t_basic();
        int c; logic [31:0] r;
        do_reset();
        raise(3'd1, 8'h01, 8'h02);
        chk(type_mask == 8'h02, "R2 mask set", type_mask, 8'h02);
        watch(4, c, r);
        chk(c == 0, "R6 no slot no delivery", c, 0);
        post(1);
        watch(4, c, r);
        chk(c == 1, "R6 delivered once", c, 1);
        chk(r == 32'h0002_0101, "R7 packing", r, 32'h0002_0101);
        chk(open_slots == 0, "R6 slot consumed", open_slots, 0);
    endtask

    task automatic t_dedup();
        int c; logic [31:0] r;
        do_reset();
        post(2);
        raise(3'd1, 8'h01, 8'h02);
        watch(3, c, r);
        raise(3'd1, 8'h07, 8'h02);
        watch(4, c, r);
        chk(c == 0, "R3 duplicate dropped", c, 0);
        chk(open_slots == 1, "R3 slot kept", open_slots, 1);
        readlog(8'h02, 1);
        chk(type_mask == 8'h02, "R8 keep holds", type_mask, 8'h02);
        readlog(8'h09, 0);
        chk(type_mask == 8'h02, "R8 other log no clear", type_mask, 8'h02);
        readlog(8'h02, 0);
        chk(type_mask == 8'h00, "R8 clear", type_mask, 0);
        raise(3'd1, 8'h07, 8'h02);
        watch(4, c, r);
        chk(c == 1 && r == 32'h0002_0701, "R8 re-arm delivers", r, 32'h0002_0701);
    endtask

    task automatic t_err_gate();
        int c; logic [31:0] r;
        do_reset();
        raise(3'd0, 8'h00, 8'h01);
        chk(type_mask == 0, "R4 error dropped", type_mask, 0);
        post(1);
        watch(3, c, r);
        chk(c == 0, "R4 nothing queued", c, 0);
        raise(3'd0, 8'h01, 8'h01);
        watch(4, c, r);
        chk(c == 1 && r == 32'h0001_0100, "R4 error delivered", r, 32'h0001_0100);
    endtask

    task automatic t_order();
        logic [31:0] got [3];
        int c = 0;
        do_reset();
        raise(3'd3, 8'h33, 8'hC0);
        raise(3'd5, 8'h55, 8'hC1);
        raise(3'd2, 8'h22, 8'hC2);
        chk(type_mask == 8'h2C, "R2 three types", type_mask, 8'h2C);
        for (int k = 0; k < 10; k++) begin
            req_post = (k < 3);
            tick();
            if (dlv_valid && c < 3) begin got[c] = dlv_result; c++; end
        end
        req_post = 0;
        chk(c == 3, "R6 three deliveries", c, 3);
        chk(got[0] == 32'h00C0_3303, "R6 order first", got[0], 32'h00C0_3303);
        chk(got[1] == 32'h00C1_5505, "R6 order second", got[1], 32'h00C1_5505);
        chk(got[2] == 32'h00C2_2202, "R6 order third", got[2], 32'h00C2_2202);
    endtask

    task automatic t_slots();
        do_reset();
        post(1);
        chk(open_slots == 1, "R5 one post", open_slots, 1);
        post(4);
        chk(open_slots == 4, "R5 ceiling", open_slots, 4);
    endtask

    task automatic t_race();
        int c; logic [31:0] r;
        do_reset();
        post(2);
        raise(3'd1, 8'h01, 8'h02);
        watch(3, c, r);
        ev_valid = 1; ev_type = 3'd1; ev_info = 8'h05; ev_log = 8'h02;
        rd_valid = 1; rd_log = 8'h02; rd_keep = 0;
        tick(); idle();
        chk(type_mask[1] == 1, "R9 bit stays set", type_mask, 8'h02);
        watch(4, c, r);
        chk(c == 1 && r == 32'h0002_0501, "R9 event accepted", r, 32'h0002_0501);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_dedup();
        t_err_gate();
        t_order();
        t_slots();
        t_race();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule